// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice with Ripple Chain

This block is a purely combinational arithmetic logic unit built from narrow slices. Each slice takes two operand words, a three-bit operation code and a carry input. It returns a result word, a carry output and a signed overflow flag. Eight operation codes are decoded:
- three arithmetic operations: addition, and subtraction in either operand order;
- three bitwise operations: XOR, OR and AND;
- two constant results: all zeros and all ones.

Subtraction is formed by adding the one's complement of the subtrahend. The caller supplies the extra one through the carry input of the lowest slice. No carry is injected inside the block.

The top level chains a parameterised number of slices by ripple carry. Each slice's carry output feeds the carry input of the slice above it. The chain carry output and the overflow flag come from the most significant slice. The default build is four slices of four bits, which gives a 16-bit ALU. A single-slice build gives a stand-alone four-bit unit.

Top module: `alu_chain`

## Requirements
- R1: Operation code value 3 (sel_i = 3'b011, where bit 0 is the least significant select line) gives f_o = A + B + cin_i, modulo 2^N, where N is the chain width.
- R2: Operation code value 1 gives f_o = B + ~A + cin_i, modulo 2^N. With cin_i = 1 this is the two's-complement difference B − A.
- R3: Operation code value 2 gives f_o = A + ~B + cin_i, modulo 2^N. With cin_i = 1 this is the two's-complement difference A − B.
- R4: In the three arithmetic codes, cout_o equals bit N of the unsigned sum of the two adder operands and cin_i.
- R5: In the arithmetic codes, ovr_o is 1 exactly when the adder result, read as a signed N-bit value, differs from the true signed sum. This equals the XOR of the carry into the top bit and the carry out of it.
- R6: Code 4 gives A XOR B, code 5 gives A OR B, and code 6 gives A AND B. Each is computed bit by bit.
- R7: Code 0 drives f_o to all zeros, and code 7 drives it to all ones, whatever A, B and cin_i are.
- R8: In codes 0 and 4 to 7, cout_o and ovr_o are both 0, and cin_i has no effect on f_o.
- R9: Slices are chained with each carry output feeding the next slice's carry input. The results across the full N = SLICE_W*SLICES bits therefore match whole-word integer arithmetic. ovr_o reports signed overflow at bit N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | SLICE_W*SLICES | Operand A |
| b_i | input | SLICE_W*SLICES | Operand B |
| sel_i | input | 3 | Operation code (bit 0 is the least significant select) |
| cin_i | input | 1 | Carry into the lowest slice |
| f_o | output | SLICE_W*SLICES | Result word |
| cout_o | output | 1 | Carry out of the top slice |
| ovr_o | output | 1 | Signed overflow of the top slice |

## Verification
The bench builds two instances.

The first uses SLICE_W = 4 and SLICES = 1. This makes a single slice small enough to sweep every combination of operands, carry input and operation code: 4096 vectors. That sweep reaches every carry, overflow and carry-ignored corner of R1 to R8.

The second uses the default SLICE_W = 4 and SLICES = 4. Random and directed 16-bit vectors exercise carry propagation across slice boundaries and overflow at the top bit, as required by R9. The directed vectors include the most positive plus one, the most negative minus one, and an all-ones plus carry.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

   typedef enum logic [2:0] {
      OP_CLEAR   = 3'd0,
      OP_B_SUB_A = 3'd1,
      OP_A_SUB_B = 3'd2,
      OP_ADD     = 3'd3,
      OP_XOR     = 3'd4,
      OP_OR      = 3'd5,
      OP_AND     = 3'd6,
      OP_SET     = 3'd7
   } alu_op_e;

   function automatic logic op_is_arith(alu_op_e op);
      return (op == OP_ADD) || (op == OP_B_SUB_A) || (op == OP_A_SUB_B);
   endfunction

endpackage

// File: rtl/alu_operand_mux.sv
`timescale 1ns/1ps
module alu_operand_mux #(
   parameter int W = 4
) (
   input  alu_pkg::alu_op_e op_i,
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   output logic [W-1:0]     x_o,
   output logic [W-1:0]     y_o
);
   import alu_pkg::*;

   always_comb begin
      x_o = a_i;
      y_o = b_i;
      case (op_i)
         OP_B_SUB_A: begin
            x_o = b_i;
            y_o = ~a_i;
         end
         OP_A_SUB_B: begin
            x_o = a_i;
            y_o = ~b_i;
         end
         default: begin
            x_o = a_i;
            y_o = b_i;
         end
      endcase
   end

endmodule

// File: rtl/alu_ripple_adder.sv
`timescale 1ns/1ps
module alu_ripple_adder #(
   parameter int W = 4
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cmsb_o,
   output logic         cout_o
);
   logic [W:0] c;

   assign c[0] = cin_i;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign sum_o[k] = x_i[k] ^ y_i[k] ^ c[k];
      assign c[k+1]   = (x_i[k] & y_i[k]) | (c[k] & (x_i[k] ^ y_i[k]));
   end

   assign cmsb_o = c[W-1];
   assign cout_o = c[W];

   always_comb begin
      assert_carry_out_R4: assert ({cout_o, sum_o} ==
         ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i}))
         else $error("ripple sum/carry disagree with word addition");
   end

endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit #(
   parameter int W = 4
) (
   input  alu_pkg::alu_op_e op_i,
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   output logic [W-1:0]     f_o
);
   import alu_pkg::*;

   always_comb begin
      case (op_i)
         OP_XOR:  f_o = a_i ^ b_i;
         OP_OR:   f_o = a_i | b_i;
         OP_AND:  f_o = a_i & b_i;
         OP_SET:  f_o = '1;
         default: f_o = '0;
      endcase
   end

endmodule

// File: rtl/alu_slice.sv
`timescale 1ns/1ps
module alu_slice #(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   sel_i,
   input  logic         cin_i,
   output logic [W-1:0] f_o,
   output logic         cout_o,
   output logic         ovr_o
);
   import alu_pkg::*;

   alu_op_e      op;
   logic         arith;
   logic [W-1:0] x, y, sum, lf;
   logic         c_msb, c_out;

   assign op    = alu_op_e'(sel_i);
   assign arith = op_is_arith(op);

   alu_operand_mux #(.W(W)) u_mux (
      .op_i(op), .a_i(a_i), .b_i(b_i), .x_o(x), .y_o(y)
   );

   alu_ripple_adder #(.W(W)) u_add (
      .x_i(x), .y_i(y), .cin_i(cin_i),
      .sum_o(sum), .cmsb_o(c_msb), .cout_o(c_out)
   );

   alu_logic_unit #(.W(W)) u_logic (
      .op_i(op), .a_i(a_i), .b_i(b_i), .f_o(lf)
   );

   assign f_o    = arith ? sum : lf;
   assign cout_o = arith & c_out;
   assign ovr_o  = arith & (c_msb ^ c_out);

   always_comb begin
      if (arith) begin
         assert_signed_ovr_R5: assert (ovr_o ==
            ((x[W-1] == y[W-1]) && (f_o[W-1] != x[W-1])))
            else $error("overflow flag disagrees with sign rule");
      end
      if (op == OP_XOR) begin
         assert_xor_R6: assert (f_o == ((a_i | b_i) & ~(a_i & b_i)))
            else $error("xor result wrong");
      end
      if (op == OP_CLEAR) begin
         assert_clear_R7: assert (f_o == '0) else $error("clear not zero");
      end
      if (op == OP_SET) begin
         assert_preset_R7: assert (&f_o) else $error("preset not ones");
      end
      if (!arith) begin
         assert_quiet_flags_R8: assert (!cout_o && !ovr_o)
            else $error("flags active in non-arithmetic code");
      end
   end

endmodule

// File: rtl/alu_chain.sv
`timescale 1ns/1ps
module alu_chain #(
   parameter int SLICE_W = 4,
   parameter int SLICES  = 4,
   localparam int TOTAL_W = SLICE_W * SLICES
) (
   input  logic [TOTAL_W-1:0] a_i,
   input  logic [TOTAL_W-1:0] b_i,
   input  logic [2:0]         sel_i,
   input  logic               cin_i,
   output logic [TOTAL_W-1:0] f_o,
   output logic               cout_o,
   output logic               ovr_o
);
   import alu_pkg::*;

   if (SLICE_W < 2) begin : g_bad_width
      $error("SLICE_W must be at least 2");
   end
   if (SLICES < 1) begin : g_bad_count
      $error("SLICES must be at least 1");
   end

   logic [SLICES:0]   carry;
   logic [SLICES-1:0] ovr_vec;

   assign carry[0] = cin_i;

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      alu_slice #(.W(SLICE_W)) u_slice (
         .a_i   (a_i[s*SLICE_W +: SLICE_W]),
         .b_i   (b_i[s*SLICE_W +: SLICE_W]),
         .sel_i (sel_i),
         .cin_i (carry[s]),
         .f_o   (f_o[s*SLICE_W +: SLICE_W]),
         .cout_o(carry[s+1]),
         .ovr_o (ovr_vec[s])
      );
   end

   assign cout_o = carry[SLICES];
   assign ovr_o  = ovr_vec[SLICES-1];

   alu_op_e        op_chk;
   logic [TOTAL_W:0] whole;

   assign op_chk = alu_op_e'(sel_i);

   always_comb begin
      case (op_chk)
         OP_B_SUB_A: whole = {1'b0, b_i} + {1'b0, ~a_i} + {{TOTAL_W{1'b0}}, cin_i};
         OP_A_SUB_B: whole = {1'b0, a_i} + {1'b0, ~b_i} + {{TOTAL_W{1'b0}}, cin_i};
         default:    whole = {1'b0, a_i} + {1'b0, b_i} + {{TOTAL_W{1'b0}}, cin_i};
      endcase
      if (op_is_arith(op_chk)) begin
         assert_chain_sum_R9: assert ({cout_o, f_o} == whole)
            else $error("chained result disagrees with whole-word sum");
      end else begin
         assert_chain_quiet_R8: assert (!cout_o && (ovr_vec == '0))
            else $error("chain flags active in non-arithmetic code");
      end
   end

endmodule

// File: tb/tb_alu_chain.sv
`timescale 1ns/1ps
module tb_alu_chain;

   localparam int SW = 4;
   localparam int NS = 4;
   localparam int TW = SW * NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [TW-1:0] a16 = '0, b16 = '0;
   logic [2:0]    sel16 = '0;
   logic          cin16 = 1'b0;
   logic [TW-1:0] f16;
   logic          co16, ov16;

   logic [SW-1:0] a4 = '0, b4 = '0;
   logic [2:0]    sel4 = '0;
   logic          cin4 = 1'b0;
   logic [SW-1:0] f4;
   logic          co4, ov4;

   alu_chain #(.SLICE_W(SW), .SLICES(NS)) dut (
      .a_i(a16), .b_i(b16), .sel_i(sel16), .cin_i(cin16),
      .f_o(f16), .cout_o(co16), .ovr_o(ov16)
   );

   alu_chain #(.SLICE_W(SW), .SLICES(1)) dut_slice (
      .a_i(a4), .b_i(b4), .sel_i(sel4), .cin_i(cin4),
      .f_o(f4), .cout_o(co4), .ovr_o(ov4)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   task automatic check(string tag, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // Behavioural model over integers, independent of slice structure
   function automatic void ref_alu(int n, int op, longint a, longint b, int cin,
                                   output longint f, output int co, output int ov);
      longint mask, half, x, y, s, sx, sy, ss;
      mask = (64'sd1 << n) - 1;
      half = 64'sd1 << (n - 1);
      co = 0;
      ov = 0;
      case (op)
         0: f = 0;
         7: f = mask;
         4: f = a ^ b;
         5: f = a | b;
         6: f = a & b;
         default: begin
            if (op == 1)      begin x = b; y = (~a) & mask; end
            else if (op == 2) begin x = a; y = (~b) & mask; end
            else              begin x = a; y = b; end
            s  = x + y + cin;
            f  = s & mask;
            co = int'((s >> n) & 1);
            sx = (x >= half) ? x - (mask + 1) : x;
            sy = (y >= half) ? y - (mask + 1) : y;
            ss = sx + sy + cin;
            ov = (ss > half - 1 || ss < -half) ? 1 : 0;
         end
      endcase
   endfunction

   function automatic string op_tag(int op);
      case (op)
         3: return "R1";
         1: return "R2";
         2: return "R3";
         0, 7: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic run_slice(int op, int a, int b, int cin);
      longint ef;
      int eco, eov;
      bit ar;
      @(posedge clk);
      #1;
      a4 = SW'(a); b4 = SW'(b); sel4 = 3'(op); cin4 = cin[0];
      @(negedge clk);
      ref_alu(SW, op, a, b, cin, ef, eco, eov);
      ar = (op >= 1 && op <= 3);
      // non-arithmetic expected F ignores cin, so both cin values check R8
      check(op_tag(op), longint'(f4), ef);
      check(ar ? "R4" : "R8", longint'(co4), longint'(eco));
      check(ar ? "R5" : "R8", longint'(ov4), longint'(eov));
   endtask

   task automatic run_chain(int op, int a, int b, int cin);
      longint ef;
      int eco, eov;
      @(posedge clk);
      #1;
      a16 = TW'(a); b16 = TW'(b); sel16 = 3'(op); cin16 = cin[0];
      @(negedge clk);
      ref_alu(TW, op, longint'(a) & 64'hFFFF, longint'(b) & 64'hFFFF, cin, ef, eco, eov);
      check("R9 result", longint'(f16), ef);
      check("R9 carry", longint'(co16), longint'(eco));
      check("R9 overflow", longint'(ov16), longint'(eov));
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all inputs zero selects clear (R7)
      check("R7 reset result", longint'(f16), 0);
      check("R8 reset carry", longint'(co16), 0);
      check("R8 reset overflow", longint'(ov16), 0);
      rst_n = 1'b1;

      // exhaustive single slice sweep
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int c = 0; c < 2; c++)
                  run_slice(op, a, b, c);

      // directed 16-bit corners (R9)
      run_chain(3, 16'h7FFF, 16'h0001, 0);
      run_chain(2, 16'h8000, 16'h0001, 1);
      run_chain(1, 16'h0001, 16'h8000, 1);
      run_chain(3, 16'hFFFF, 16'h0000, 1);
      run_chain(3, 16'h8000, 16'h8000, 0);
      run_chain(2, 16'h1234, 16'h1234, 1);
      run_chain(0, 16'hFFFF, 16'hFFFF, 1);
      run_chain(7, 16'h0000, 16'h0000, 0);

      // random 16-bit vectors; subtractions use forced carry-in
      for (int i = 0; i < 3000; i++) begin
         int op, a, b, c;
         op = int'($urandom_range(0, 7));
         a  = int'($urandom & 32'hFFFF);
         b  = int'($urandom & 32'hFFFF);
         c  = (op == 1 || op == 2) ? 1 : int'($urandom & 1);
         run_chain(op, a, b, c);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule